// File: doc/BRIEF.md
# Long-Interval Periodic Pulse Generator

This block produces a brief active-high pulse after a long quiet stretch and then repeats forever. A 14-bit counter advances by one on every cycle where a single-cycle tick enable is high. The tick enable is the block's time base and stands in for a slow oscillator. The top counter bit is the pulse. On its own, that bit would stay high for half of the full count range.

To keep the pulse short, a three-input AND decode watches the top bit and two lower bits chosen by parameter. When all three are set, the next tick returns the counter to zero. The pulse then lasts only a few dozen ticks, and that width is not a power-of-two fraction of the period.

The low and high times both scale with the tick rate. With a tick of about 0.22 s, the default decode gives roughly half an hour low and a few seconds high. A synchronous active-high reset restarts the cycle at count zero.

Top module: `long_pulse_timer`

## Requirements
- R1: While `rst_i` is high at a clock edge, the next state is `count_o` = 0 and `pulse_o` = 0, whatever `tick_i` is.
- R2: Outside reset, `count_o` changes only on a cycle where `tick_i` is high. On a cycle with `tick_i` low, the count holds.
- R3: After reset, `pulse_o` stays low for exactly 2^(CNT_W-1) ticks (8192 by default) and rises on the tick that takes `count_o` to 2^(CNT_W-1).
- R4: `pulse_o` always equals bit CNT_W-1 of `count_o`.
- R5: When bit CNT_W-1 and bits DEC_IDX_A and DEC_IDX_B of `count_o` are all 1, the next tick sets `count_o` to 0 and `pulse_o` falls.
- R6: Each pulse lasts 2^DEC_IDX_A + 2^DEC_IDX_B + 1 ticks (25 by default). Every later low interval lasts 2^(CNT_W-1) ticks, so one period is 8217 ticks by default.
- R7: `count_o` never exceeds 2^(CNT_W-1) + 2^DEC_IDX_A + 2^DEC_IDX_B (8216 by default), so the counter never wraps through its full range.
- R8: DEC_IDX_A and DEC_IDX_B must be distinct and below CNT_W-1. Any other setting stops elaboration.
- R9: A reset applied during the pulse ends it at once. The following tick takes `count_o` to 1, and a full low interval of 2^(CNT_W-1) ticks follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Single-cycle advance enable (time base) |
| pulse_o | output | 1 | Periodic output pulse, active high |
| count_o | output | CNT_W | Current counter value |

## Verification
A corrupted count shows on `count_o` on the first tick after the fault. Within at most one period it also distorts the measured low or high duration of `pulse_o`.

A decode that picks the wrong bits, or that misses its match, changes the pulse width. That error is visible at the first falling edge of the pulse, about 8200 ticks after reset. A missed match also lets the count run past its bound toward the wrap point.

A separately registered pulse that drifts from the counter's top bit is caught on the tick where the two first disagree.

// File: rtl/ltp_pkg.sv
package ltp_pkg;
  // Count at which the decode fires: top bit plus the two selected low bits.
  function automatic int unsigned match_value(int unsigned w, int unsigned a, int unsigned b);
    return (32'd1 << (w - 1)) + (32'd1 << a) + (32'd1 << b);
  endfunction

  // Ticks spent with the pulse high, from rise to fall.
  function automatic int unsigned high_ticks(int unsigned a, int unsigned b);
    return (32'd1 << a) + (32'd1 << b) + 32'd1;
  endfunction
endpackage

// File: rtl/ltp_counter.sv
module ltp_counter #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             adv_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] nxt_o
);
  logic [CNT_W-1:0] cnt_q;

  // Value the counter takes on the next enabled tick.
  always_comb begin
    if (clr_i) nxt_o = '0;
    else       nxt_o = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)      cnt_q <= '0;
    else if (adv_i) cnt_q <= nxt_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ltp_decode.sv
module ltp_decode #(
  parameter int unsigned CNT_W     = 14,
  parameter int unsigned DEC_IDX_A = 4,
  parameter int unsigned DEC_IDX_B = 3
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic             hit_o
);
  localparam int unsigned MSB = CNT_W - 1;

  logic [CNT_W-1:0] sel;

  // Bits outside the decode are forced to 1 so they do not affect the AND.
  for (genvar i = 0; i < CNT_W; i++) begin : g_sel
    if (i == MSB || i == DEC_IDX_A || i == DEC_IDX_B) begin : g_use
      assign sel[i] = cnt_i[i];
    end else begin : g_skip
      assign sel[i] = 1'b1;
    end
  end

  assign hit_o = &sel;
endmodule

// File: rtl/long_pulse_timer.sv
module long_pulse_timer #(
  parameter int unsigned CNT_W     = 14,
  parameter int unsigned DEC_IDX_A = 4,
  parameter int unsigned DEC_IDX_B = 3
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tick_i,
  output logic             pulse_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int unsigned MSB = CNT_W - 1;

  // R8: the decode bits must be distinct and sit below the top bit.
  if (DEC_IDX_A >= MSB || DEC_IDX_B >= MSB || DEC_IDX_A == DEC_IDX_B) begin : g_bad_idx
    $error("long_pulse_timer: decode indices must be distinct and below CNT_W-1");
  end

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic             hit;
  logic             pulse_q;

  ltp_decode #(
    .CNT_W    (CNT_W),
    .DEC_IDX_A(DEC_IDX_A),
    .DEC_IDX_B(DEC_IDX_B)
  ) u_decode (
    .cnt_i(cnt),
    .hit_o(hit)
  );

  ltp_counter #(
    .CNT_W(CNT_W)
  ) u_counter (
    .clk_i(clk_i),
    .rst_i(rst_i),
    .adv_i(tick_i),
    .clr_i(hit),
    .cnt_o(cnt),
    .nxt_o(cnt_nxt)
  );

  // Registered pulse, loaded from the counter's next top bit.
  always_ff @(posedge clk_i) begin
    if (rst_i)       pulse_q <= 1'b0;
    else if (tick_i) pulse_q <= cnt_nxt[MSB];
  end

  assign pulse_o = pulse_q;
  assign count_o = cnt;
endmodule

// File: rtl/ltp_checker.sv
module ltp_checker #(
  parameter int unsigned CNT_W     = 14,
  parameter int unsigned DEC_IDX_A = 4,
  parameter int unsigned DEC_IDX_B = 3
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             tick_i,
  input logic             pulse_o,
  input logic [CNT_W-1:0] count_o
);
  localparam int unsigned MSB = CNT_W - 1;
  localparam logic [CNT_W-1:0] TOP_VAL =
    CNT_W'(ltp_pkg::match_value(CNT_W, DEC_IDX_A, DEC_IDX_B));

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    rst_i |=> (count_o == '0 && !pulse_o)); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
    !tick_i |=> $stable(count_o)); // R2

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick_i && count_o != TOP_VAL) |=> count_o == $past(count_o) + 1'b1); // R2

  AST_PULSE_MSB: assert property (@(posedge clk_i) disable iff (rst_i)
    pulse_o == count_o[MSB]); // R4

  AST_DECODE_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick_i && count_o == TOP_VAL) |=> (count_o == '0 && $fell(pulse_o))); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (rst_i)
    count_o <= TOP_VAL); // R7
endmodule

bind long_pulse_timer ltp_checker #(
  .CNT_W    (CNT_W),
  .DEC_IDX_A(DEC_IDX_A),
  .DEC_IDX_B(DEC_IDX_B)
) u_ltp_checker (
  .clk_i  (clk_i),
  .rst_i  (rst_i),
  .tick_i (tick_i),
  .pulse_o(pulse_o),
  .count_o(count_o)
);

// File: tb/long_pulse_timer_tb_top.sv
module long_pulse_timer_tb_top;
  localparam int unsigned CNT_W     = 14;
  localparam int unsigned DEC_IDX_A = 4;
  localparam int unsigned DEC_IDX_B = 3;
  localparam int unsigned MSB       = CNT_W - 1;
  localparam int LOW_T  = 2 ** MSB;
  localparam int HIGH_T = 2 ** DEC_IDX_A + 2 ** DEC_IDX_B + 1;
  localparam int TOP_V  = 2 ** MSB + 2 ** DEC_IDX_A + 2 ** DEC_IDX_B;

  logic             clk = 1'b0;
  logic             rst_i = 1'b1;
  logic             tick_i = 1'b0;
  logic             pulse_o;
  logic [CNT_W-1:0] count_o;

  int n_chk  = 0;
  int n_fail = 0;
  int msb_err = 0;
  int max_cnt = 0;

  always #5 clk = ~clk;

  long_pulse_timer #(
    .CNT_W    (CNT_W),
    .DEC_IDX_A(DEC_IDX_A),
    .DEC_IDX_B(DEC_IDX_B)
  ) dut_i (
    .clk_i  (clk),
    .rst_i  (rst_i),
    .tick_i (tick_i),
    .pulse_o(pulse_o),
    .count_o(count_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One tick: tick_i is high for one cycle and low for one cycle.
  // Outputs are sampled at the negedge after the update.
  task automatic tick_once();
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    if (pulse_o != count_o[MSB]) msb_err++;
    if (int'(count_o) > max_cnt) max_cnt = int'(count_o);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_i = 1'b1; tick_i = 1'b1;
    @(negedge clk); rst_i = 1'b0; tick_i = 1'b0;
  endtask

  // Returns the number of ticks until pulse_o reaches the given level.
  task automatic ticks_until(input logic lvl, output int n);
    n = 0;
    while (pulse_o != lvl) begin
      tick_once();
      n++;
    end
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 count after reset", int'(count_o), 0);
    check("R1 pulse after reset", int'(pulse_o), 0);
  endtask

  task automatic t_hold();
    do_reset();
    tick_once(); tick_once(); tick_once();
    repeat (6) @(negedge clk);
    check("R2 count holds with tick low", int'(count_o), 3);
  endtask

  task automatic t_first_low();
    int n;
    do_reset();
    ticks_until(1'b1, n);
    check("R3 first low interval", n, LOW_T);
    check("R3 count at rise", int'(count_o), LOW_T);
  endtask

  task automatic t_cycles();
    int n;
    do_reset();
    msb_err = 0; max_cnt = 0;
    ticks_until(1'b1, n);
    for (int c = 0; c < 3; c++) begin
      ticks_until(1'b0, n);
      check("R6 high interval", n, HIGH_T);
      check("R5 count after decode", int'(count_o), 0);
      ticks_until(1'b1, n);
      check("R6 low interval", n, LOW_T);
    end
    check("R4 pulse matches count msb", msb_err, 0);
    check("R7 max count", max_cnt, TOP_V);
  endtask

  task automatic t_reset_mid();
    int n;
    do_reset();
    ticks_until(1'b1, n);
    repeat (5) tick_once();
    @(negedge clk); rst_i = 1'b1;
    @(negedge clk); rst_i = 1'b0;
    check("R9 pulse cleared mid pulse", int'(pulse_o), 0);
    check("R9 count cleared mid pulse", int'(count_o), 0);
    tick_once();
    check("R9 count one tick after reset", int'(count_o), 1);
    ticks_until(1'b1, n);
    check("R9 low interval after reset", n + 1, LOW_T);
  endtask

  initial begin
    t_reset();
    t_hold();
    t_first_low();
    t_cycles();
    t_reset_mid();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule